// File: doc/BRIEF.md
# Dual-Edge Delay Tuning Sequencer

This block sweeps the sampling setup of a memory-card interface to find a working input delay. It runs two phases in a fixed order: response tuning, then data tuning. In each phase it tries every delay tap on the rising sample edge and then every tap on the falling sample edge. For each setting it issues one tuning request and waits for a pass or fail result. The results build a 32-bit pass map for each edge.

When a phase's sweep ends, the block searches both maps for their best window of consecutive passing taps. It picks one edge from the window lengths and drives the winning edge and tap onto its setting outputs. The tuning transfer itself is outside the block. It is reached through a request channel and a result pulse.

Flow-control rules:
- The request channel is valid/ready. `req_valid_o` stays high, with the current edge and tap held stable, until `req_ready_i` is seen high at a clock edge.
- The result channel has no back-pressure. One `res_valid_i` pulse is taken only while an accepted request is waiting for its result. A pulse at any other time is dropped.

Top module: `tune_seq`

## Requirements
- R1: A `start_i` pulse while idle begins a sweep. Requests come out in this order: response path (`req_data_o`=0) rising edge (edge value 0) taps 0..31, then response falling edge (edge value 1) taps 0..31, then the same two sweeps for the data path (`req_data_o`=1). The current edge and tap appear on that path's edge and tap outputs and stay stable while a request is pending. The tap advances only after a result.
- R2: Bit i of an edge's pass map is set only when the result for tap i has `res_pass_i`=1. A `res_valid_i` pulse while no accepted request is waiting has no effect. An accepted request is followed by no new request until its result arrives.
- R3: The window search scans each map from tap 0 upward over maximal runs of ones. It keeps the longest run, and the earliest one on equal length. It stops scanning once a run of at least 8 closes while the kept run starts below tap 4.
- R4: The phase of a window starting at tap 0 is its length divided by 3 (integer division). Any other window's phase is its start plus half its length (integer division). An empty map gives the failure code 0xFF. The applied tap is the low 5 bits of the chosen phase, so 31 on failure.
- R5: Response tuning picks the falling edge only when the falling window is strictly longer. Otherwise it picks rising.
- R6: Data tuning picks rising whenever the rising window length is at least 10. Otherwise it picks the strictly longer window, with ties going to rising. The data read-edge and write-edge outputs always carry the same chosen value.
- R7: If the response choice has phase 0xFF, the block finishes with status 01 and issues no data requests. The data outputs stay at edge 0, tap 0.
- R8: On completion `done_o` pulses for one cycle. `status_o` carries 00 (success), 01 (response failure) or 10 (data failure) and holds until the next completion.
- R9: `start_i` is ignored while busy.
- R10: After reset the block is idle. All outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a tuning run (pulse, taken only when idle) |
| busy_o | output | 1 | High while a run is in progress |
| req_valid_o | output | 1 | Tuning request valid |
| req_ready_i | input | 1 | Tuning request accepted |
| req_data_o | output | 1 | Path of the request: 0 response, 1 data |
| res_valid_i | input | 1 | One-cycle result pulse |
| res_pass_i | input | 1 | Result: 1 pass, 0 fail |
| cmd_edge_o | output | 1 | Response sample edge: 0 rising, 1 falling |
| cmd_tap_o | output | 5 | Response delay tap |
| dat_rd_edge_o | output | 1 | Data read sample edge |
| dat_wr_edge_o | output | 1 | Data write sample edge |
| dat_tap_o | output | 5 | Data delay tap |
| done_o | output | 1 | Run finished (one-cycle pulse) |
| status_o | output | 2 | Run outcome code |

## Verification
A wrong sweep counter or edge flag shows at the very next request: the edge or tap on that path's outputs disagrees with the expected position in the 128-step order. A corrupted pass map, window register or selection rule stays hidden during the sweep. It appears only at the end of the phase, as a wrong applied edge or tap, a wrong status, or data requests that should not happen after a response failure. Spurious result pulses and restart pulses are mixed into the stimulus, so any state they wrongly touch shows up in the same final comparison.

// File: rtl/tune_pkg.sv
package tune_pkg;

  typedef enum logic [1:0] {
    TS_OK       = 2'b00,
    TS_RSP_FAIL = 2'b01,
    TS_DAT_FAIL = 2'b10
  } tune_status_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_FIND_GO,
    ST_FIND_WAIT,
    ST_APPLY
  } seq_state_e;

endpackage

// File: rtl/tune_win_finder.sv
// Bit-serial search for the best run of passing taps in one pass map.
module tune_win_finder #(
  parameter int TAP_W       = 5,
  parameter int PH_W        = 8,
  parameter int EARLY_LEN   = 8,
  parameter int EARLY_START = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    go_i,
  input  logic [(1<<TAP_W)-1:0]   map_i,
  output logic                    fin_o,
  output logic [TAP_W:0]          len_o,
  output logic [PH_W-1:0]         phase_o
);
  localparam int LEN_W = TAP_W + 1;

  logic               scan_q, fin_q;
  logic [TAP_W-1:0]   idx_q, cur_start_q, best_start_q;
  logic [LEN_W-1:0]   cur_len_q, best_len_q;

  logic               bit_c, last_c, close_c, better_c, stop_c;
  logic [LEN_W-1:0]   run_len_c, nbl_c;
  logic [TAP_W-1:0]   run_start_c, nbs_c;
  logic [TAP_W-1:0]   ph_tap_c;

  always_comb begin
    bit_c       = map_i[idx_q];
    last_c      = (idx_q == '1);
    run_len_c   = cur_len_q + LEN_W'(bit_c);
    run_start_c = (cur_len_q == '0) ? idx_q : cur_start_q;
    close_c     = !bit_c || last_c;
    better_c    = close_c && (run_len_c > best_len_q);
    nbl_c       = better_c ? run_len_c   : best_len_q;
    nbs_c       = better_c ? run_start_c : best_start_q;
    stop_c      = close_c && (run_len_c >= LEN_W'(EARLY_LEN)) &&
                  (nbs_c < TAP_W'(EARLY_START));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_q       <= 1'b0;
      fin_q        <= 1'b0;
      idx_q        <= '0;
      cur_start_q  <= '0;
      cur_len_q    <= '0;
      best_start_q <= '0;
      best_len_q   <= '0;
    end else begin
      fin_q <= 1'b0;
      if (go_i) begin
        scan_q       <= 1'b1;
        idx_q        <= '0;
        cur_start_q  <= '0;
        cur_len_q    <= '0;
        best_start_q <= '0;
        best_len_q   <= '0;
      end else if (scan_q) begin
        best_len_q   <= nbl_c;
        best_start_q <= nbs_c;
        cur_len_q    <= bit_c ? run_len_c : '0;
        cur_start_q  <= run_start_c;
        if (stop_c || last_c) begin
          scan_q <= 1'b0;
          fin_q  <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (best_start_q == '0) ph_tap_c = TAP_W'(best_len_q / LEN_W'(3));
    else                    ph_tap_c = best_start_q + TAP_W'(best_len_q >> 1);
  end

  assign fin_o   = fin_q;
  assign len_o   = best_len_q;
  assign phase_o = (best_len_q == '0) ? '1 : PH_W'(ph_tap_c);

endmodule

// File: rtl/tune_edge_pick.sv
// Chooses rising or falling edge from the two window results.
module tune_edge_pick #(
  parameter int TAP_W    = 5,
  parameter int PH_W     = 8,
  parameter int RISE_MIN = 10
) (
  input  logic               is_data_i,
  input  logic [TAP_W:0]     rise_len_i,
  input  logic [TAP_W:0]     fall_len_i,
  input  logic [PH_W-1:0]    rise_ph_i,
  input  logic [PH_W-1:0]    fall_ph_i,
  output logic               pick_fall_o,
  output logic [TAP_W-1:0]   pick_tap_o,
  output logic               pick_fail_o
);
  localparam int LEN_W = TAP_W + 1;

  logic            rise_strong;
  logic [PH_W-1:0] ph;

  always_comb begin
    rise_strong = is_data_i && (rise_len_i >= LEN_W'(RISE_MIN));
    pick_fall_o = !rise_strong && (fall_len_i > rise_len_i);
    ph          = pick_fall_o ? fall_ph_i : rise_ph_i;
    pick_tap_o  = ph[TAP_W-1:0];
    pick_fail_o = &ph;
  end

endmodule

// File: rtl/tune_seq.sv
module tune_seq
  import tune_pkg::*;
#(
  parameter int TAP_W         = 5,
  parameter int PH_W          = 8,
  parameter int DATA_RISE_MIN = 10,
  parameter int EARLY_LEN     = 8,
  parameter int EARLY_START   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             busy_o,
  output logic             req_valid_o,
  input  logic             req_ready_i,
  output logic             req_data_o,
  input  logic             res_valid_i,
  input  logic             res_pass_i,
  output logic             cmd_edge_o,
  output logic [TAP_W-1:0] cmd_tap_o,
  output logic             dat_rd_edge_o,
  output logic             dat_wr_edge_o,
  output logic [TAP_W-1:0] dat_tap_o,
  output logic             done_o,
  output logic [1:0]       status_o
);
  localparam int NTAP  = 1 << TAP_W;
  localparam int LEN_W = TAP_W + 1;
  localparam int NEDGE = 2;

  seq_state_e                  state_q;
  tune_status_e                status_q;
  logic                        path_q, done_q;
  logic                        cmd_edge_q, dat_edge_q;
  logic [TAP_W-1:0]            cmd_tap_q, dat_tap_q;
  logic [NEDGE-1:0][NTAP-1:0]  map_q;
  logic [NEDGE-1:0]            fin_seen_q;

  logic                        cur_fall;
  logic [TAP_W-1:0]            cur_tap;
  logic                        find_go;
  logic [NEDGE-1:0]            win_fin;
  logic [NEDGE-1:0][LEN_W-1:0] win_len;
  logic [NEDGE-1:0][PH_W-1:0]  win_ph;
  logic                        pick_fall, pick_fail;
  logic [TAP_W-1:0]            pick_tap;

  assign cur_fall = path_q ? dat_edge_q : cmd_edge_q;
  assign cur_tap  = path_q ? dat_tap_q  : cmd_tap_q;
  assign find_go  = (state_q == ST_FIND_GO);

  // index 0: rising-edge map, index 1: falling-edge map
  for (genvar e = 0; e < NEDGE; e++) begin : g_edge
    tune_win_finder #(
      .TAP_W(TAP_W), .PH_W(PH_W),
      .EARLY_LEN(EARLY_LEN), .EARLY_START(EARLY_START)
    ) u_find (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_i    (find_go),
      .map_i   (map_q[e]),
      .fin_o   (win_fin[e]),
      .len_o   (win_len[e]),
      .phase_o (win_ph[e])
    );
  end

  tune_edge_pick #(
    .TAP_W(TAP_W), .PH_W(PH_W), .RISE_MIN(DATA_RISE_MIN)
  ) u_pick (
    .is_data_i   (path_q),
    .rise_len_i  (win_len[0]),
    .fall_len_i  (win_len[1]),
    .rise_ph_i   (win_ph[0]),
    .fall_ph_i   (win_ph[1]),
    .pick_fall_o (pick_fall),
    .pick_tap_o  (pick_tap),
    .pick_fail_o (pick_fail)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      status_q   <= TS_OK;
      path_q     <= 1'b0;
      done_q     <= 1'b0;
      cmd_edge_q <= 1'b0;
      cmd_tap_q  <= '0;
      dat_edge_q <= 1'b0;
      dat_tap_q  <= '0;
      map_q      <= '0;
      fin_seen_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            path_q     <= 1'b0;
            cmd_edge_q <= 1'b0;
            cmd_tap_q  <= '0;
            dat_edge_q <= 1'b0;
            dat_tap_q  <= '0;
            map_q      <= '0;
            state_q    <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (req_ready_i) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (res_valid_i) begin
            map_q[cur_fall][cur_tap] <= res_pass_i;
            if (cur_tap == TAP_W'(NTAP - 1)) begin
              if (!cur_fall) begin
                if (path_q) begin dat_edge_q <= 1'b1; dat_tap_q <= '0; end
                else        begin cmd_edge_q <= 1'b1; cmd_tap_q <= '0; end
                state_q <= ST_REQ;
              end else begin
                state_q <= ST_FIND_GO;
              end
            end else begin
              if (path_q) dat_tap_q <= dat_tap_q + 1'b1;
              else        cmd_tap_q <= cmd_tap_q + 1'b1;
              state_q <= ST_REQ;
            end
          end
        end
        ST_FIND_GO: begin
          fin_seen_q <= '0;
          state_q    <= ST_FIND_WAIT;
        end
        ST_FIND_WAIT: begin
          fin_seen_q <= fin_seen_q | win_fin;
          if (&(fin_seen_q | win_fin)) state_q <= ST_APPLY;
        end
        ST_APPLY: begin
          if (!path_q) begin
            cmd_edge_q <= pick_fall;
            cmd_tap_q  <= pick_tap;
            if (pick_fail) begin
              status_q <= TS_RSP_FAIL;
              done_q   <= 1'b1;
              state_q  <= ST_IDLE;
            end else begin
              path_q     <= 1'b1;
              dat_edge_q <= 1'b0;
              dat_tap_q  <= '0;
              map_q      <= '0;
              state_q    <= ST_REQ;
            end
          end else begin
            dat_edge_q <= pick_fall;
            dat_tap_q  <= pick_tap;
            status_q   <= pick_fail ? TS_DAT_FAIL : TS_OK;
            done_q     <= 1'b1;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign req_valid_o   = (state_q == ST_REQ);
  assign req_data_o    = path_q;
  assign cmd_edge_o    = cmd_edge_q;
  assign cmd_tap_o     = cmd_tap_q;
  assign dat_rd_edge_o = dat_edge_q;
  assign dat_wr_edge_o = dat_edge_q;
  assign dat_tap_o     = dat_tap_q;
  assign done_o        = done_q;
  assign status_o      = status_q;

endmodule

// File: rtl/tune_seq_chk.sv
module tune_seq_chk #(
  parameter int TAP_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             req_valid_o,
  input logic             req_ready_i,
  input logic             req_data_o,
  input logic             cmd_edge_o,
  input logic [TAP_W-1:0] cmd_tap_o,
  input logic             dat_rd_edge_o,
  input logic             dat_wr_edge_o,
  input logic [TAP_W-1:0] dat_tap_o,
  input logic             done_o,
  input logic [1:0]       status_o
);

  a_r1_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(cmd_tap_o) &&
      $stable(dat_tap_o) && $stable(cmd_edge_o) && $stable(dat_rd_edge_o) &&
      $stable(req_data_o));

  a_r1_first_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> req_valid_o && !req_data_o && !cmd_edge_o && cmd_tap_o == '0);

  a_r2_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && req_ready_i |=> !req_valid_o);

  a_r7_rsp_fail_data_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && status_o == 2'b01 |-> dat_tap_o == '0 && !dat_rd_edge_o && !dat_wr_edge_o);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_done_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && status_o != 2'b11);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !start_i |=> !busy_o && $stable(cmd_tap_o) && $stable(dat_tap_o) &&
      $stable(cmd_edge_o) && $stable(dat_wr_edge_o) && $stable(status_o));

endmodule

bind tune_seq tune_seq_chk #(.TAP_W(TAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_data_o(req_data_o),
  .cmd_edge_o(cmd_edge_o), .cmd_tap_o(cmd_tap_o),
  .dat_rd_edge_o(dat_rd_edge_o), .dat_wr_edge_o(dat_wr_edge_o),
  .dat_tap_o(dat_tap_o), .done_o(done_o), .status_o(status_o)
);

// File: tb/tune_seq_tb.sv
module tune_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       start_i = 1'b0, req_ready_i = 1'b0, res_valid_i = 1'b0, res_pass_i = 1'b0;
  logic       busy_o, req_valid_o, req_data_o, cmd_edge_o, dat_rd_edge_o, dat_wr_edge_o, done_o;
  logic [4:0] cmd_tap_o, dat_tap_o;
  logic [1:0] status_o;

  tune_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_data_o(req_data_o),
    .res_valid_i(res_valid_i), .res_pass_i(res_pass_i),
    .cmd_edge_o(cmd_edge_o), .cmd_tap_o(cmd_tap_o),
    .dat_rd_edge_o(dat_rd_edge_o), .dat_wr_edge_o(dat_wr_edge_o),
    .dat_tap_o(dat_tap_o), .done_o(done_o), .status_o(status_o)
  );

  int total = 0, bad = 0;
  logic [31:0] mp [4];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // R3 R4: best window {len[5:0], phase[7:0]}
  function automatic logic [13:0] win(input logic [31:0] m);
    int s, l, sf, lf;
    logic [7:0] ph;
    if (m == 32'd0) return {6'd0, 8'hFF};
    s = 0; sf = 0; lf = 0;
    while (s < 32) begin
      l = 0;
      while (s + l < 32 && m[(s + l) % 32]) l++;
      if (l > lf) begin sf = s; lf = l; end
      s += (l > 0) ? l : 1;
      if (l >= 8 && sf < 4) break;
    end
    ph = (sf == 0) ? 8'(lf / 3) : 8'((sf + lf / 2) % 32);
    return {6'(lf), ph};
  endfunction

  // R5 R6: edge choice
  task automatic pick(input logic [31:0] mr, input logic [31:0] mf, input bit is_data,
                      output bit fall, output logic [7:0] ph);
    logic [13:0] wr, wf;
    wr = win(mr); wf = win(mf);
    if (is_data && wr[13:8] >= 6'd10) fall = 1'b0;
    else fall = (wf[13:8] > wr[13:8]);
    ph = fall ? wf[7:0] : wr[7:0];
  endtask

  function automatic logic [31:0] run(input int s, input int l);
    logic [63:0] v;
    v = ((64'd1 << l) - 64'd1) << s;
    return v[31:0];
  endfunction

  function automatic logic [31:0] gen_map();
    case ($urandom % 4)
      0: return $urandom;
      1: return run($urandom % 32, $urandom % 33);
      2: return run($urandom % 20, $urandom % 13) | ($urandom & $urandom & $urandom);
      default: return run($urandom % 10, $urandom % 9) | run(12 + $urandom % 12, $urandom % 21);
    endcase
  endfunction

  task automatic run_case(input string name, input logic [31:0] rr, input logic [31:0] rf,
                          input logic [31:0] dr, input logic [31:0] df);
    bit rfall, dfall, rfail, dfail, got_done, pbit;
    logic [7:0] rph, dph;
    logic [1:0] exp_st, st_hold;
    int seq, limit, phase, dly, cyc, ap, ae, at;
    mp[0] = rr; mp[1] = rf; mp[2] = dr; mp[3] = df;
    pick(rr, rf, 1'b0, rfall, rph);
    pick(dr, df, 1'b1, dfall, dph);
    rfail = (rph == 8'hFF);
    dfail = (dph == 8'hFF);
    limit = rfail ? 64 : 128;
    seq = 0; phase = 0; dly = 0; cyc = 0; got_done = 1'b0; pbit = 1'b0;
    @(negedge clk); start_i = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      start_i = 1'b0;
      res_valid_i = 1'b0;
      if (done_o) begin got_done = 1'b1; break; end
      if (cyc > 6000) break;
      if (phase == 3) phase = 0;
      if (phase == 1) begin
        req_ready_i = 1'b0; phase = 2; dly = $urandom % 3;
      end else if (phase == 2) begin
        if (dly == 0) begin res_valid_i = 1'b1; res_pass_i = pbit; phase = 3; end
        else dly--;
      end else if (req_valid_o && ($urandom % 3 != 0)) begin
        ap = seq / 64; ae = (seq / 32) % 2; at = seq % 32;
        // R1/R9 sweep order, unaffected by start pulses while busy
        chk(seq < limit && req_data_o == ap[0] &&
            (req_data_o ? dat_rd_edge_o : cmd_edge_o) == ae[0] &&
            (req_data_o ? dat_tap_o : cmd_tap_o) == at[4:0],
            {name, " R1/R9 request order"},
            32'({req_data_o, req_data_o ? dat_rd_edge_o : cmd_edge_o, req_data_o ? dat_tap_o : cmd_tap_o}),
            32'({ap[0], ae[0], at[4:0]}));
        pbit = (seq < 128) ? mp[(ap * 2 + ae) % 4][at] : 1'b0;
        seq++;
        req_ready_i = 1'b1; phase = 1;
      end else if ($urandom % 5 == 0) begin
        // R2 stray result pulse while nothing waits
        res_valid_i = 1'b1; res_pass_i = 1'($urandom % 2);
      end
      if (busy_o && ($urandom % 60 == 0)) start_i = 1'b1;
    end
    req_ready_i = 1'b0; start_i = 1'b0; res_valid_i = 1'b0;
    chk(got_done, {name, " R8 done before watchdog"}, 32'(got_done), 32'd1);
    chk(seq == limit, {name, " R7 request count"}, 32'(seq), 32'(limit));
    exp_st = rfail ? 2'b01 : (dfail ? 2'b10 : 2'b00);
    chk(status_o == exp_st, {name, " R8 status"}, 32'(status_o), 32'(exp_st));
    chk(cmd_edge_o == rfall, {name, " R2 R5 response edge"}, 32'(cmd_edge_o), 32'(rfall));
    chk(cmd_tap_o == rph[4:0], {name, " R3 R4 response tap"}, 32'(cmd_tap_o), 32'(rph[4:0]));
    if (rfail) begin
      chk(dat_tap_o == 5'd0 && !dat_rd_edge_o && !dat_wr_edge_o, {name, " R7 data untouched"},
          32'({dat_rd_edge_o, dat_wr_edge_o, dat_tap_o}), 32'd0);
    end else begin
      chk(dat_rd_edge_o == dfall && dat_wr_edge_o == dfall, {name, " R6 data edges"},
          32'({dat_rd_edge_o, dat_wr_edge_o}), 32'({dfall, dfall}));
      chk(dat_tap_o == dph[4:0], {name, " R3 R4 data tap"}, 32'(dat_tap_o), 32'(dph[4:0]));
    end
    st_hold = status_o;
    @(negedge clk);
    @(negedge clk);
    chk(!done_o && !busy_o && status_o == st_hold, {name, " R8 pulse and hold"},
        32'({done_o, busy_o, status_o}), 32'({2'b00, st_hold}));
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R8 act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!busy_o && !req_valid_o && !req_data_o && !done_o && status_o == 2'b00 &&
        cmd_tap_o == 5'd0 && dat_tap_o == 5'd0 && !cmd_edge_o && !dat_rd_edge_o && !dat_wr_edge_o,
        "R10 reset outputs",
        32'({busy_o, req_valid_o, done_o, status_o, cmd_tap_o, dat_tap_o}), 32'd0);

    run_case("all-pass", 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF);
    run_case("rsp-empty", 32'h0, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    run_case("fall-longer", 32'h000000F0, 32'h00FFFF00, 32'h000003FF, 32'hFFFF0000);
    run_case("data-rise9", 32'h0FF00000, 32'h00000000, 32'h00001FF0, 32'hFFFFF000);
    run_case("data-empty", 32'h0000FF00, 32'h000FF000, 32'h0, 32'h0);
    run_case("early-stop", 32'hFFFF03FC, 32'h0, 32'hFFFF03FC, 32'h0);
    run_case("tie-rise", 32'h00007C00, 32'h000000F8, 32'h00007C00, 32'h000000F8);
    run_case("rise-only-empty", 32'h0, 32'h30000000, 32'h0, 32'h00000001);
    for (int k = 0; k < 14; k++) begin
      run_case("random", gen_map(), gen_map(), gen_map(), gen_map());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule